// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a single-cycle-deselect pipelined synchronous SRAM with byte-lane writes. Every address, control and write-data input is taken on the rising clock edge. Read data leaves through an output register, so a read sampled at one edge appears on the bus after the next edge. The shared data bus is three-stated under an asynchronous output enable. The word is built from byte lanes of nine bits each, with two lanes by default. The array depth is a parameter and is kept small for simulation.

An access can start from either of two address strobes. The processor strobe is qualified by the first chip select. The controller strobe is not qualified. An internal two-bit sequencer captures the start address, and the advance input steps it through a four-word burst. The burst follows either linear or interleaved order, chosen by a static strap. An active reset input only puts the pipeline into the deselected state. The array contents are not initialised.

Top module: `burst_sram`

## Requirements
- R1: A read sampled at edge n places the addressed word on the bus after edge n+1, while the output enable is low.
- R2: Reads started on consecutive edges produce a new word on the bus after each following edge.
- R3: A processor strobe is ignored while the first chip select (active low) is high. An access already in progress continues unchanged.
- R4: After reset, and during the first cycle after a strobe moves the device from deselected to selected, the bus is high impedance.
- R5: A strobe edge without the full chip-select set deselects the device. The bus is high impedance right after that edge, even if a read was pending.
- R6: A processor-strobe access takes two edges. At the strobe edge the write controls and the advance input are ignored. A write requested on the next edge goes to the captured address.
- R7: A low global write stores every byte lane, whatever the lane enable and lane selects are.
- R8: Without global write, lane i (data bits 9i+8..9i) is stored only when the lane write enable is low and lane_sel_n[i] is low.
- R9: An access whose lane mask is empty (no global write and no selected lane) is a read and leaves the array unchanged.
- R10: In a burst, the two low address bits for step k are base+k mod 4 when order_ilv is 0, and base XOR k when it is 1. A low advance input moves one step; a high advance input repeats the current address.
- R11: The output enable acts combinationally on the bus driver. Raising it and lowering it again does not disturb the word held in the output register.
- R12: A controller-strobe write stores the data present at its own strobe edge. A read of the same address on the next edge returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; clears the pipeline to deselected |
| pstrobe_n | input | 1 | Processor address strobe, active low, qualified by sel_a_n |
| cstrobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| order_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| data | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The assertions assume that order_ilv changes only while the device is deselected. They also assume that nothing else drives the data bus while the block drives it. The stimulus changes the strap only right after a deselect edge. Whenever the bench drives write data, it holds the output enable high, so the two drivers never overlap. Without these limits, the burst and three-state checks would be comparing against a moving target. The array is never read before it is written, because the bench fills every address with a known pattern before any check that reads it back.

// File: rtl/sram_pkg.sv
package sram_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } acc_op_e;

endpackage

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_pkg::*;
#(
   parameter int AW    = 6,
   parameter int LANES = 2,
   parameter int BB    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pstrobe_n,
   input  logic             cstrobe_n,
   input  logic             advance_n,
   input  logic             sel_a_n,
   input  logic             sel_b,
   input  logic             sel_c_n,
   input  logic             wr_all_n,
   input  logic             wr_lane_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             order_ilv,
   input  logic [AW-1:0]    addr,
   output acc_op_e          acc_op,
   output logic [AW-1:0]    acc_addr,
   output logic [LANES-1:0] wr_mask,
   output logic             desel_ev,
   output logic             sel_q
);

   logic [AW-1:0]    base_q;
   logic [BB-1:0]    idx_q, idx_n;
   logic             sel_n, load;
   logic             p_edge, c_edge, full;
   logic [LANES-1:0] mask_raw;

   function automatic logic [BB-1:0] seq_low(input logic [BB-1:0] b,
                                             input logic [BB-1:0] k,
                                             input logic ilv);
      return ilv ? (b ^ k) : (b + k);
   endfunction

   always_comb begin
      p_edge = !pstrobe_n && !sel_a_n;
      c_edge = !p_edge && !cstrobe_n;
      full   = !sel_a_n && sel_b && !sel_c_n;
      if (!wr_all_n)          mask_raw = '1;
      else if (!wr_lane_en_n) mask_raw = ~lane_sel_n;
      else                    mask_raw = '0;

      acc_op   = OP_NONE;
      acc_addr = base_q;
      wr_mask  = '0;
      desel_ev = 1'b0;
      sel_n    = sel_q;
      idx_n    = idx_q;
      load     = 1'b0;

      if (p_edge || c_edge) begin
         if (full) begin
            sel_n    = 1'b1;
            idx_n    = '0;
            load     = 1'b1;
            acc_addr = addr;
            if (c_edge && (|mask_raw)) begin
               acc_op  = OP_WRITE;
               wr_mask = mask_raw;
            end else begin
               acc_op  = OP_READ;
            end
         end else begin
            sel_n    = 1'b0;
            desel_ev = 1'b1;
         end
      end else if (sel_q) begin
         idx_n    = idx_q + {{(BB-1){1'b0}}, !advance_n};
         acc_addr = {base_q[AW-1:BB], seq_low(base_q[BB-1:0], idx_n, order_ilv)};
         if (|mask_raw) begin
            acc_op  = OP_WRITE;
            wr_mask = mask_raw;
         end else begin
            acc_op  = OP_READ;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         base_q <= '0;
         idx_q  <= '0;
      end else begin
         sel_q <= sel_n;
         idx_q <= idx_n;
         if (load) base_q <= addr;
      end
   end

   AST_PSTROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstrobe_n && sel_a_n && cstrobe_n) |=> ($stable(sel_q) && $stable(base_q))); // R3

endmodule

// File: rtl/sram_array.sv
module sram_array #(
   parameter int AW     = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [AW-1:0]           wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [AW-1:0]           rd_addr,
   output logic [LANES*LANE_W-1:0] rd_word
);

   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_mask[g]) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end

      assign rd_word[g*LANE_W +: LANE_W] = cells[rd_addr];
   end

endmodule

// File: rtl/sram_outpipe.sv
module sram_outpipe #(
   parameter int AW = 6,
   parameter int DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr_in,
   input  logic          desel_ev,
   input  logic [DW-1:0] rd_word,
   input  logic          out_en_n,
   output logic [AW-1:0] rd_addr_q,
   output logic [DW-1:0] out_q,
   output logic          out_vld_q,
   output logic          drive
);

   logic rd_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend_q <= 1'b0;
         rd_addr_q <= '0;
         out_vld_q <= 1'b0;
         out_q     <= '0;
      end else begin
         rd_pend_q <= rd_req;
         if (rd_req) rd_addr_q <= rd_addr_in;
         out_vld_q <= rd_pend_q && !desel_ev;
         if (rd_pend_q) out_q <= rd_word;
      end
   end

   assign drive = out_vld_q && !out_en_n;

   AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      desel_ev |=> !out_vld_q); // R5

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import sram_pkg::*;
#(
   parameter int AW         = 6,
   parameter int LANES      = 2,
   parameter int LANE_W     = 9,
   parameter int BURST_BITS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pstrobe_n,
   input  logic                    cstrobe_n,
   input  logic                    advance_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    wr_all_n,
   input  logic                    wr_lane_en_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    order_ilv,
   input  logic [AW-1:0]           addr,
   input  logic                    out_en_n,
   inout  wire  [LANES*LANE_W-1:0] data
);

   localparam int DW = LANES * LANE_W;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram: LANES and LANE_W must be at least 1");
   end
   if (BURST_BITS < 1 || AW <= BURST_BITS) begin : g_bad_aw
      $error("burst_sram: AW must exceed BURST_BITS, which must be at least 1");
   end

   acc_op_e          acc_op;
   logic [AW-1:0]    acc_addr, rd_addr_q;
   logic [LANES-1:0] wr_mask;
   logic             desel_ev, sel_q, out_vld_q, drive;
   logic [DW-1:0]    rd_word, out_q;

   sram_ctl #(.AW(AW), .LANES(LANES), .BB(BURST_BITS)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n), .advance_n(advance_n),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
      .order_ilv(order_ilv), .addr(addr),
      .acc_op(acc_op), .acc_addr(acc_addr), .wr_mask(wr_mask),
      .desel_ev(desel_ev), .sel_q(sel_q)
   );

   sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .wr_mask(wr_mask), .wr_addr(acc_addr), .wr_data(data),
      .rd_addr(rd_addr_q), .rd_word(rd_word)
   );

   sram_outpipe #(.AW(AW), .DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .rd_req(acc_op == OP_READ), .rd_addr_in(acc_addr), .desel_ev(desel_ev),
      .rd_word(rd_word), .out_en_n(out_en_n),
      .rd_addr_q(rd_addr_q), .out_q(out_q), .out_vld_q(out_vld_q), .drive(drive)
   );

   assign data = drive ? out_q : 'z;

   logic p_hit, full_hit;
   assign p_hit    = !pstrobe_n && !sel_a_n;
   assign full_hit = !sel_a_n && sel_b && !sel_c_n;

   AST_FIRST_CYCLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_q) |-> !out_vld_q); // R4

   AST_PSTROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      p_hit |-> (acc_op != OP_WRITE)); // R6

   AST_PSTROBE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (p_hit && full_hit) |=> ((pstrobe_n && cstrobe_n && advance_n) -> (acc_addr == $past(addr)))); // R6

   AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_all_n && acc_op == OP_WRITE) |-> (&wr_mask)); // R7

endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
   localparam int AW = 6, LANES = 2, LANE_W = 9, DW = 18, DEPTH = 64;
   localparam logic [DW-1:0] HIZ = '1;

   logic clk = 1'b0;
   logic rst_n, pstrobe_n, cstrobe_n, advance_n, sel_a_n, sel_b, sel_c_n;
   logic wr_all_n, wr_lane_en_n, order_ilv, out_en_n;
   logic [LANES-1:0] lane_sel_n;
   logic [AW-1:0] addr;
   logic tb_oe;
   logic [DW-1:0] tb_wd;
   wire  [DW-1:0] dq_bus;

   for (genvar i = 0; i < DW; i++) begin : g_pu
      pullup (dq_bus[i]);
   end
   assign dq_bus = tb_oe ? tb_wd : 'z;

   burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut (
      .clk(clk), .rst_n(rst_n), .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n),
      .advance_n(advance_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
      .order_ilv(order_ilv), .addr(addr), .out_en_n(out_en_n), .data(dq_bus)
   );

   always #2 clk = ~clk;

   int nvec = 0, nfail = 0;
   bit done = 0;
   logic [DW-1:0] mdl [DEPTH];

   // fields: gw_n, lane_en_n, lane_sel_n[1:0], addr[5:0], data[17:0]
   localparam logic [27:0] VEC [8] = '{
      {1'b0, 1'b1, 2'b11, 6'd3,  18'h12345},
      {1'b1, 1'b0, 2'b10, 6'd3,  18'h0AAAA},
      {1'b1, 1'b0, 2'b01, 6'd5,  18'h15555},
      {1'b1, 1'b0, 2'b11, 6'd7,  18'h00001},
      {1'b0, 1'b0, 2'b00, 6'd9,  18'h2F0F0},
      {1'b1, 1'b0, 2'b00, 6'd10, 18'h01234},
      {1'b1, 1'b1, 2'b00, 6'd12, 18'h3AAAA},
      {1'b0, 1'b0, 2'b11, 6'd14, 18'h0C3C3}
   };

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic chk(string tag, logic [DW-1:0] exp);
      nvec++;
      if (dq_bus !== exp) begin
         nfail++;
         $display("FAIL %s: bus=%h expected=%h", tag, dq_bus, exp);
      end
   endtask

   task automatic set_idle();
      pstrobe_n = 1; cstrobe_n = 1; advance_n = 1;
      wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = '1;
      sel_a_n = 0; sel_b = 1; sel_c_n = 0;
   endtask

   task automatic c_acc(logic [AW-1:0] a, logic gw, logic be, logic [1:0] bs, logic [DW-1:0] d);
      logic [1:0] m;
      m = !gw ? 2'b11 : (!be ? ~bs : 2'b00);
      set_idle();
      cstrobe_n = 0; addr = a; wr_all_n = gw; wr_lane_en_n = be; lane_sel_n = bs;
      if (m != 0) begin out_en_n = 1; tb_wd = d; tb_oe = 1; end
      tick();
      for (int l = 0; l < LANES; l++)
         if (m[l]) mdl[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      tb_oe = 0; out_en_n = 0;
      set_idle();
   endtask

   task automatic c_read(logic [AW-1:0] a);
      c_acc(a, 1'b1, 1'b1, 2'b11, '0);
   endtask

   task automatic desel();
      set_idle(); cstrobe_n = 0; sel_b = 0; tick(); set_idle();
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: bus=%h expected=%h", dq_bus, HIZ);
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; tb_oe = 0; tb_wd = '0; out_en_n = 0; order_ilv = 0; addr = '0;
      set_idle(); pstrobe_n = 1; cstrobe_n = 1;
      repeat (3) tick();
      rst_n = 1;
      tick();
      chk("R4 reset hiz", HIZ);

      // fill every word with a known pattern (global writes)
      for (int a = 0; a < DEPTH; a++)
         c_acc(AW'(a), 1'b0, 1'b1, 2'b11, 18'((a * 313 + 1110) & 18'h1FFFF));
      desel();

      // table: writes through lane masks and global write (R7 R8 R9 R12)
      for (int i = 0; i < 8; i++)
         c_acc(VEC[i][23:18], VEC[i][27], VEC[i][26], VEC[i][25:24], VEC[i][17:0]);
      desel();
      // back-to-back read-back (R2), first cycle after select is hiz (R4)
      for (int i = 0; i < 8; i++) begin
         c_read(VEC[i][23:18]);
         if (i == 0) chk("R4 first cycle hiz", HIZ);
         else chk("R2 R7 R8 R9 readback", mdl[VEC[i-1][23:18]]);
      end
      tick();
      chk("R2 readback last", mdl[VEC[7][23:18]]);
      desel();

      // latency and output enable (R1 R11)
      c_read(6'h21);
      chk("R4 hiz after select", HIZ);
      tick();
      chk("R1 read latency", mdl[6'h21]);
      out_en_n = 1; #1;
      chk("R11 oe high hiz", HIZ);
      out_en_n = 0; #1;
      chk("R11 oe restore", mdl[6'h21]);
      desel();
      chk("R5 deselect hiz", HIZ);

      // controller write then read same address (R12)
      c_acc(6'h22, 1'b0, 1'b1, 2'b11, 18'h0BEEF);
      c_read(6'h22);
      tick();
      chk("R12 write then read", 18'h0BEEF);
      desel();

      // processor strobe ignored while sel_a_n high (R3)
      c_read(6'h24);
      tick();
      chk("R3 before", mdl[6'h24]);
      pstrobe_n = 0; sel_a_n = 1; addr = 6'h25;
      tick();
      set_idle();
      tick();
      chk("R3 strobe ignored", mdl[6'h24]);
      desel();

      // processor strobe: write controls ignored on first edge (R6)
      set_idle(); pstrobe_n = 0; addr = 6'h26; wr_all_n = 0; advance_n = 0;
      out_en_n = 1; tb_wd = 18'h01111; tb_oe = 1;
      tick();
      tb_oe = 0; set_idle();
      tick();
      out_en_n = 0; #1;
      chk("R6 first edge write ignored", mdl[6'h26]);
      desel();

      // processor strobe: write on second edge to captured address (R6)
      set_idle(); pstrobe_n = 0; addr = 6'h27; out_en_n = 1;
      tick();
      set_idle(); addr = 6'h30; wr_all_n = 0; tb_wd = 18'h02222; tb_oe = 1;
      tick();
      mdl[6'h27] = 18'h02222;
      tb_oe = 0; set_idle(); out_en_n = 0;
      desel();
      c_read(6'h27);
      c_read(6'h28);
      chk("R6 second edge write", 18'h02222);
      tick();
      chk("R6 neighbour untouched", mdl[6'h28]);
      desel();

      // bursts from base 0x1D in both orders (R10)
      for (int ilv = 0; ilv < 2; ilv++) begin
         order_ilv = ilv[0];
         desel();
         c_read(6'h1D);
         advance_n = 0;
         for (int k = 0; k < 5; k++) begin
            logic [1:0] lo;
            if (k == 3) advance_n = 1;
            tick();
            lo = ilv[0] ? (2'b01 ^ 2'(k > 3 ? 3 : k)) : 2'(1 + (k > 3 ? 3 : k));
            chk(ilv[0] ? "R10 interleaved burst" : "R10 linear burst", mdl[{4'h7, lo}]);
         end
         desel();
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule